// File: doc/BRIEF.md
# Power Management Event Controller

The block holds a free-running power management timer, a latched event status word, an event enable word and a control word. It merges enabled events into a level-sensitive system control interrupt (SCI). Status bits are cleared by writing ones to them. A timer overflow event is raised each time the most significant timer bit changes state, which happens every 2^23 ticks with the default width. A power button input raises an event only while that event is enabled. The timer advances once per cycle in which the tick-enable strobe is high, so the strobe is expected to run at the 3.579545 MHz power management rate.

Software reaches the registers over a simple synchronous bus with separate 16-bit and 32-bit accesses. Reads are combinational from the current state, and writes take effect at the clock edge. A write to the control word can request soft power-off through a one-cycle pulse. A separate two-byte command/status port carries two fixed command codes that turn SCI delivery on or off. A write to the command byte can also raise a one-cycle system management interrupt (SMI) request.

Top module: `pm_evt_ctrl`

## Requirements
- R1: The timer is TMR_W bits wide (default 24). It increments by one on each clock with `tick_en` high, otherwise holds, and wraps to zero. A 32-bit read at offset 0x08 returns it zero-extended.
- R2: Only the low 6 address bits are decoded. 16-bit offsets: 0x00 status, 0x02 enable, 0x04 control. Any other read, including a 16-bit read at 0x08 and a 32-bit read at any other offset, returns 0. 32-bit writes change nothing.
- R3: A 16-bit write to status clears each status bit written as 1 and leaves the bits written as 0 unchanged.
- R4: Status bit 0 is set in the cycle in which timer bit TMR_W-1 changes state. If a write-one-to-clear of that bit lands in the same cycle, the bit stays set.
- R5: `sci` is high exactly when status AND enable is nonzero in bit 10, 8, 5 or 0. Other bits have no effect.
- R6: A `pwrbtn_evt` cycle sets status bit 8 only when enable bit 8 is 1; otherwise status is unchanged.
- R7: Control bit 13 (suspend request) is never stored and reads 0. All other control bits written are stored.
- R8: A control write with bit 13 set and bits 12:10 equal to 0 makes `poweroff_req` high for exactly one cycle, starting at the next edge. Other values of bits 12:10 cause no pulse.
- R9: Writing 0xF1 to the command byte (`apm_sel`=0) sets control bit 0, and writing 0xF0 clears it. Other codes leave control bit 0 alone. The byte written reads back on `apm_rdata`.
- R10: A command-byte write raises `smi_req` for one cycle, starting at the next edge, only when `smi_cfg_en` is 1. The status byte (`apm_sel`=1) is plain read/write storage and raises no SMI.
- R11: Reset clears the timer and every register, so `sci`, `poweroff_req` and `smi_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer advance strobe |
| pwrbtn_evt | input | 1 | Power button event, one cycle per press |
| smi_cfg_en | input | 1 | Allows command-byte writes to raise SMI |
| req_valid | input | 1 | Bus access valid (writes only) |
| req_write | input | 1 | 1 = write |
| req_wide | input | 1 | 0 = 16-bit access, 1 = 32-bit access |
| req_addr | input | ADDR_W | Byte address, low 6 bits decoded |
| req_wdata | input | 32 | Write data (16-bit writes use bits 15:0) |
| rsp_rdata | output | 32 | Combinational read data for req_addr/req_wide |
| apm_wr | input | 1 | Command/status byte write strobe |
| apm_sel | input | 1 | 0 = command byte, 1 = status byte |
| apm_wdata | input | 8 | Byte write data |
| apm_rdata | output | 8 | Selected byte |
| sci | output | 1 | Level system control interrupt |
| poweroff_req | output | 1 | One-cycle soft power-off request |
| smi_req | output | 1 | One-cycle SMI request |

## Verification
A wrong status bit shows up on `sci` in the same cycle it is latched, and on a status read at once. This includes an overflow lost to a same-cycle clear, or a power button event latched while disabled. A timer fault shows only as a wrong count on the 32-bit read, or as a missing overflow event. To keep overflows reachable in a short run, the bench uses a reduced timer width and places a clear exactly on the wrap edge. Decode faults in the control word show up through the pulse outputs one cycle after the write and through the control readback.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_AW = 6;
  localparam logic [REG_AW-1:0] OFS_STS = 6'h00;
  localparam logic [REG_AW-1:0] OFS_EN  = 6'h02;
  localparam logic [REG_AW-1:0] OFS_CTL = 6'h04;
  localparam logic [REG_AW-1:0] OFS_TMR = 6'h08;
  // event bit positions shared by status and enable
  localparam int EV_TMR = 0;
  localparam int EV_PWR = 8;
  localparam logic [15:0] SCI_SRC_MASK = 16'h0521; // bits 10,8,5,0
  // control word fields
  localparam int CT_SCI_ON = 0;
  localparam int CT_SUSP   = 13;
  localparam int CT_SLP_LO = 10;
  localparam int CT_SLP_W  = 3;
  localparam logic [7:0] CMD_SCI_ON  = 8'hF1;
  localparam logic [7:0] CMD_SCI_OFF = 8'hF0;
endpackage

// File: rtl/pm_tick_timer.sv
module pm_tick_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [TMR_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam int MSB = TMR_W - 1;
  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = cnt_d[MSB] ^ cnt_q[MSB];

  // R1: count holds without a tick
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));
  // R1: each tick moves the count by one
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/pm_apm_port.sv
module pm_apm_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic       sel_i,
  input  logic [7:0] wdata_i,
  input  logic       smi_cfg_en_i,
  output logic [7:0] rdata_o,
  output logic       sci_on_o,
  output logic       sci_off_o,
  output logic       smi_o
);
  import pm_evt_pkg::*;
  logic [7:0] cmd_q, cmd_d, stat_q, stat_d;
  logic       smi_q, smi_d;
  logic       cmd_wr;

  assign cmd_wr = wr_i && !sel_i;

  always_comb begin
    cmd_d  = cmd_wr ? wdata_i : cmd_q;
    stat_d = (wr_i && sel_i) ? wdata_i : stat_q;
    smi_d  = cmd_wr && smi_cfg_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      stat_q <= '0;
      smi_q  <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      stat_q <= stat_d;
      smi_q  <= smi_d;
    end
  end

  assign rdata_o   = sel_i ? stat_q : cmd_q;
  assign sci_on_o  = cmd_wr && (wdata_i == CMD_SCI_ON);
  assign sci_off_o = cmd_wr && (wdata_i == CMD_SCI_OFF);
  assign smi_o     = smi_q;

  // R10: an SMI pulse always traces back to a gated command write
  p_smi_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    smi_q |-> $past(wr_i && !sel_i && smi_cfg_en_i));
  // R10: SMI lasts one cycle unless another command write follows
  p_smi_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    smi_q && !cmd_wr |=> !smi_q);
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  logic [5:0]  addr_i,
  input  logic [15:0] wdata_i,
  input  logic        ovf_i,
  input  logic        pwrbtn_i,
  input  logic        sci_on_i,
  input  logic        sci_off_i,
  output logic [15:0] sts_o,
  output logic [15:0] en_o,
  output logic [15:0] ctl_o,
  output logic        sci_o,
  output logic        poweroff_o
);
  import pm_evt_pkg::*;
  logic [15:0] sts_q, sts_d, en_q, en_d, ctl_q, ctl_d;
  logic        poff_q, poff_d;
  logic        wr_sts, wr_en, wr_ctl;

  assign wr_sts = wr_i && (addr_i == OFS_STS);
  assign wr_en  = wr_i && (addr_i == OFS_EN);
  assign wr_ctl = wr_i && (addr_i == OFS_CTL);

  always_comb begin
    sts_d = sts_q;
    if (wr_sts) sts_d = sts_d & ~wdata_i;
    // events are applied after the clear so they win a tie
    if (ovf_i) sts_d[EV_TMR] = 1'b1;
    if (pwrbtn_i && en_q[EV_PWR]) sts_d[EV_PWR] = 1'b1;

    en_d = wr_en ? wdata_i : en_q;

    ctl_d = wr_ctl ? wdata_i : ctl_q;
    ctl_d[CT_SUSP] = 1'b0;
    if (sci_on_i)  ctl_d[CT_SCI_ON] = 1'b1;
    if (sci_off_i) ctl_d[CT_SCI_ON] = 1'b0;

    poff_d = wr_ctl && wdata_i[CT_SUSP] &&
             (wdata_i[CT_SLP_LO +: CT_SLP_W] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= '0;
      en_q   <= '0;
      ctl_q  <= '0;
      poff_q <= 1'b0;
    end else begin
      sts_q  <= sts_d;
      en_q   <= en_d;
      ctl_q  <= ctl_d;
      poff_q <= poff_d;
    end
  end

  assign sts_o      = sts_q;
  assign en_o       = en_q;
  assign ctl_o      = ctl_q;
  assign sci_o      = |(sts_q & en_q & SCI_SRC_MASK);
  assign poweroff_o = poff_q;

  // R3: a one written to the button status clears it when no event lands
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sts && wdata_i[EV_PWR] && !pwrbtn_i |=> !sts_q[EV_PWR]);
  // R4: an overflow always leaves the timer status set
  p_ovf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_i |=> sts_q[EV_TMR]);
  // R6: a disabled button event cannot raise the status
  p_pwr_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pwrbtn_i && !en_q[EV_PWR] && !sts_q[EV_PWR] |=> !sts_q[EV_PWR]);
  // R7: a control write never leaves the suspend bit stored
  p_susp_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> !ctl_q[CT_SUSP]);
  // R8: power-off is a single-cycle pulse when no new request follows
  p_poff_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    poff_q && !wr_ctl |=> !poff_q);
  // R9: the enable command turns SCI delivery on
  p_sci_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sci_on_i |=> ctl_q[CT_SCI_ON]);
endmodule

// File: rtl/pm_evt_ctrl.sv
module pm_evt_ctrl #(
  parameter int ADDR_W = 16,
  parameter int TMR_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              pwrbtn_evt,
  input  logic              smi_cfg_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  input  logic              apm_wr,
  input  logic              apm_sel,
  input  logic [7:0]        apm_wdata,
  output logic [7:0]        apm_rdata,
  output logic              sci,
  output logic              poweroff_req,
  output logic              smi_req
);
  import pm_evt_pkg::*;
  logic [REG_AW-1:0] addr6;
  logic              unused_bits;
  logic              wr16;
  logic [TMR_W-1:0]  tmr_cnt;
  logic              tmr_ovf, sci_on, sci_off;
  logic [15:0]       sts, en, ctl;

  assign addr6       = req_addr[REG_AW-1:0];
  assign unused_bits = ^{req_addr[ADDR_W-1:REG_AW], req_wdata[31:16]};
  assign wr16        = req_valid && req_write && !req_wide;

  pm_tick_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cnt_o(tmr_cnt), .ovf_o(tmr_ovf)
  );

  pm_apm_port u_apm (
    .clk(clk), .rst_n(rst_n), .wr_i(apm_wr), .sel_i(apm_sel),
    .wdata_i(apm_wdata), .smi_cfg_en_i(smi_cfg_en), .rdata_o(apm_rdata),
    .sci_on_o(sci_on), .sci_off_o(sci_off), .smi_o(smi_req)
  );

  pm_evt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(wr16), .addr_i(addr6),
    .wdata_i(req_wdata[15:0]), .ovf_i(tmr_ovf), .pwrbtn_i(pwrbtn_evt),
    .sci_on_i(sci_on), .sci_off_i(sci_off), .sts_o(sts), .en_o(en),
    .ctl_o(ctl), .sci_o(sci), .poweroff_o(poweroff_req)
  );

  always_comb begin
    rsp_rdata = '0;
    if (!req_wide) begin
      case (addr6)
        OFS_STS: rsp_rdata = {16'h0, sts};
        OFS_EN:  rsp_rdata = {16'h0, en};
        OFS_CTL: rsp_rdata = {16'h0, ctl};
        default: rsp_rdata = '0;
      endcase
    end else if (addr6 == OFS_TMR) begin
      rsp_rdata = 32'(tmr_cnt);
    end
  end

  // R11: outputs are quiet in the first cycle out of reset
  p_reset_quiet_r11: assert property (@(posedge clk)
    $rose(rst_n) |-> !sci && !poweroff_req && !smi_req);
endmodule

// File: tb/pm_evt_ctrl_tb_top.sv
module pm_evt_ctrl_tb_top;
  localparam int TW = 10;        // reduced timer width keeps overflows reachable
  localparam int HALF = 1 << (TW - 1);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, pwrbtn_evt, smi_cfg_en;
  logic        req_valid, req_write, req_wide;
  logic [15:0] req_addr;
  logic [31:0] req_wdata, rsp_rdata;
  logic        apm_wr, apm_sel;
  logic [7:0]  apm_wdata, apm_rdata;
  logic        sci, poweroff_req, smi_req;

  int n_run = 0;
  int n_fail = 0;
  int tcount = 0;

  always #2 clk = ~clk;

  pm_evt_ctrl #(.ADDR_W(16), .TMR_W(TW)) dut_i (.*);

  // op: 0 wr16, 1 wr32, 2 rd16, 3 rd32 ; fields {op, addr, data}
  localparam logic [41:0] VEC [15] = '{
    {2'd0, 8'h02, 32'h0000_0521},
    {2'd2, 8'h02, 32'h0000_0521},
    {2'd2, 8'h42, 32'h0000_0521},
    {2'd1, 8'h02, 32'hFFFF_FFFF},
    {2'd2, 8'h02, 32'h0000_0521},
    {2'd0, 8'h04, 32'h0000_3C06},
    {2'd2, 8'h04, 32'h0000_1C06},
    {2'd2, 8'h06, 32'h0000_0000},
    {2'd2, 8'h08, 32'h0000_0000},
    {2'd3, 8'h00, 32'h0000_0000},
    {2'd0, 8'h00, 32'h0000_FFFF},
    {2'd2, 8'h00, 32'h0000_0000},
    {2'd0, 8'h02, 32'h0000_0000},
    {2'd0, 8'h04, 32'h0000_0000},
    {2'd2, 8'h04, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic wide, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_wide = wide;
    req_addr = {8'h0, a}; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic wide, input logic [7:0] a, output logic [31:0] d);
    req_valid = 1'b0; req_wide = wide; req_addr = {8'h0, a};
    #1 d = rsp_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
    tcount = (tcount + n) % (1 << TW);
  endtask

  task automatic apm_put(input logic sel, input logic [7:0] d);
    @(negedge clk);
    apm_wr = 1'b1; apm_sel = sel; apm_wdata = d;
    @(negedge clk);
    apm_wr = 1'b0;
  endtask

  task automatic button;
    @(negedge clk);
    pwrbtn_evt = 1'b1;
    @(negedge clk);
    pwrbtn_evt = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; tick_en = 0; pwrbtn_evt = 0; smi_cfg_en = 0;
    req_valid = 0; req_write = 0; req_wide = 0; req_addr = '0; req_wdata = '0;
    apm_wr = 0; apm_sel = 0; apm_wdata = '0;
    repeat (3) @(negedge clk);
    check("R11 sci in reset", {31'h0, sci}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 outputs after reset", {29'h0, sci, poweroff_req, smi_req}, 0);
    bus_rd(0, 8'h00, rd); check("R11 status reset", rd, 0);
    bus_rd(0, 8'h02, rd); check("R11 enable reset", rd, 0);
    bus_rd(0, 8'h04, rd); check("R11 control reset", rd, 0);
    bus_rd(1, 8'h08, rd); check("R11 timer reset", rd, 0);
    check("R11 apm reset", {24'h0, apm_rdata}, 0);

    // table walk: R2 decode/aliasing/ignored wide writes, R7 suspend bit
    for (int i = 0; i < 15; i++) begin
      logic [1:0]  op;
      logic [7:0]  a;
      logic [31:0] d;
      {op, a, d} = VEC[i];
      if (op[1] == 1'b0) begin
        bus_wr(op[0], a, d);
        if (a == 8'h04) check("R8 no pulse for nonzero sleep type", {31'h0, poweroff_req}, 0);
      end else begin
        bus_rd(op[0], a, rd);
        check($sformatf("R2/R7 vector %0d", i), rd, d);
      end
    end

    // R1 counting and zero extension
    ticks(300);
    bus_rd(1, 8'h08, rd); check("R1 timer count", rd, 32'(tcount));
    bus_rd(1, 8'h48, rd); check("R2 timer alias", rd, 32'(tcount));

    // R4 overflow at the half-range boundary, R5 SCI
    bus_wr(0, 8'h02, 32'h0001);
    ticks(HALF - tcount - 1);
    bus_rd(0, 8'h00, rd); check("R4 no overflow before boundary", rd, 0);
    ticks(1);
    bus_rd(0, 8'h00, rd); check("R4 overflow at boundary", rd, 32'h0001);
    check("R5 sci from overflow", {31'h0, sci}, 1);

    // R4 same-cycle clear and overflow (wrap of the full range)
    ticks((1 << TW) - tcount - 1);
    @(negedge clk);
    tick_en = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_wide = 1'b0;
    req_addr = 16'h0000; req_wdata = 32'h0001;
    @(negedge clk);
    tick_en = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    tcount = 0;
    bus_rd(0, 8'h00, rd); check("R4 overflow wins over clear", rd, 32'h0001);
    bus_rd(1, 8'h08, rd); check("R1 wrap to zero", rd, 0);
    bus_wr(0, 8'h00, 32'hFFFE);
    bus_rd(0, 8'h00, rd); check("R3 zero bits keep status", rd, 32'h0001);
    bus_wr(0, 8'h00, 32'h0001);
    bus_rd(0, 8'h00, rd); check("R3 one clears status", rd, 0);
    check("R5 sci drops after clear", {31'h0, sci}, 0);

    // R6 power button
    bus_wr(0, 8'h02, 32'h0000);
    button();
    bus_rd(0, 8'h00, rd); check("R6 disabled button ignored", rd, 0);
    check("R6 sci stays low", {31'h0, sci}, 0);
    bus_wr(0, 8'h02, 32'h0100);
    button();
    bus_rd(0, 8'h00, rd); check("R6 enabled button latched", rd, 32'h0100);
    check("R5 sci from button", {31'h0, sci}, 1);
    bus_wr(0, 8'h02, 32'hFADE);
    check("R5 masked source bits give no sci", {31'h0, sci}, 0);
    bus_wr(0, 8'h00, 32'h0100);
    bus_wr(0, 8'h02, 32'h0000);

    // R8 power-off decode
    bus_wr(0, 8'h04, 32'h2000);
    check("R8 poweroff pulse high", {31'h0, poweroff_req}, 1);
    @(negedge clk);
    check("R8 poweroff pulse one cycle", {31'h0, poweroff_req}, 0);
    bus_rd(0, 8'h04, rd); check("R7 suspend bit not stored", rd, 0);
    bus_wr(0, 8'h04, 32'h2400);
    check("R8 sleep type 1 no pulse", {31'h0, poweroff_req}, 0);
    bus_rd(0, 8'h04, rd); check("R7 other bits stored", rd, 32'h0400);

    // R9 command codes
    apm_put(0, 8'hF1);
    bus_rd(0, 8'h04, rd); check("R9 enable command", rd, 32'h0401);
    apm_sel = 0; #1 check("R9 command readback", {24'h0, apm_rdata}, 32'hF1);
    apm_put(0, 8'h55);
    bus_rd(0, 8'h04, rd); check("R9 other code no effect", rd, 32'h0401);
    apm_put(0, 8'hF0);
    bus_rd(0, 8'h04, rd); check("R9 disable command", rd, 32'h0400);
    check("R10 no smi while gated", {31'h0, smi_req}, 0);

    // R10 SMI gating and status byte
    smi_cfg_en = 1'b1;
    apm_put(0, 8'h12);
    check("R10 smi pulse high", {31'h0, smi_req}, 1);
    @(negedge clk);
    check("R10 smi one cycle", {31'h0, smi_req}, 0);
    apm_put(1, 8'hA5);
    check("R10 status byte no smi", {31'h0, smi_req}, 0);
    apm_sel = 1; #1 check("R10 status byte readback", {24'h0, apm_rdata}, 32'hA5);
    apm_sel = 0; #1 check("R10 command byte kept", {24'h0, apm_rdata}, 32'h12);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule